// File: doc/BRIEF.md
# Cluster Power Controller

This block keeps the power state of every core and every cluster in a small multi-cluster system (two clusters of four cores by default) and drives one power-enable output for each. Software controls it through a 32-bit register port with a byte address, a write strobe, write data and combinational read data. Every write names a target with an identifier: the core number sits in bits 7:0 and the cluster number in bits 15:8.

Power-down is a two-step handshake. A write to the core-off or cluster-off register only marks the target as pending. The power is removed later, in the first cycle in which the target's standby input is seen high. Power-up takes effect at once. It can come from a software request, or from an interrupt wake request on a core whose wake-enable is set. Each core keeps a two-bit code that records why it last came on. A status word for one core is read by first writing that core's identifier to the status register and then reading the same register back.

Top module: `cluster_pwr_ctrl`

## Requirements
- R1: After cold reset (rst_n low) only core 0 of cluster 0 and cluster 0 are powered. No pending flag is set, wake is disabled everywhere, every power-on reason is 2'b00, the error flag is 0 and the latched status identifier is 0.
- R2: The core field is identifier bits 7:0 and the cluster field is bits 15:8. The flat core number is cluster*CORES_PER_CLUSTER+core. Bits 23:16 and bits 31:24 of a target write are ignored. A core-targeted write whose cluster or core field is out of range changes nothing, and the same holds for a cluster-off write with an out-of-range cluster.
- R3: A write to the core-off register (0x00) for a powered core sets its pending flag. From the next cycle on, the first clock edge that sees the core's standby input high powers the core down and clears the flag. The write is ignored for a core that is off.
- R4: A write to the cluster-off register (0x08) for a powered cluster sets the cluster's pending flag. The first later edge that sees that cluster's standby input high powers the cluster and all its cores down and clears the cluster flag and its cores' flags.
- R5: A write to the core-on register (0x04) for a core that is off powers it on and sets its reason to 2'b10. It also powers its cluster on and clears the cluster's pending flag. This takes priority over an interrupt wake in the same cycle.
- R6: A core-on write for a powered core that is pending off cancels the pending state, so the core stays on even if standby is high in that cycle. For a powered core that is not pending the write is ignored and sets the error flag, which stays set until cold reset.
- R7: A write to the wakeup register (0x0C) sets the target core's wake-enable to data bit 31. A core that is off, has wake enabled and sees its wake request high powers on with reason 2'b11, together with its cluster, and the cluster's pending flag clears.
- R8: A reset-pin pulse returns power, pending and wake-enable state to the boot state of R1, with every reason set to 2'b01. The error flag and the status identifier are kept, and writes in that cycle are ignored.
- R9: A write to the status register (0x10) latches data bits 23:0. Reads of 0x10 return the latched value in bits 23:0. For a valid core, bit 31 is "any cluster on" (0 when L2_PRESENT is 0), bit 30 is cluster on, bit 29 is core on, bit 28 is wake-enable, bit 27 is cluster pending, bit 26 is core pending, and bits 25:24 are the reason. For an out-of-range identifier bits 31:24 read 0.
- R10: A powered core always has a powered cluster.
- R11: Only word-aligned addresses 0x00 to 0x10 are registers. Reads of every other address, and of the write-only offsets, return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| rst_pin_i | input | 1 | Synchronous reset-pin event |
| bus_addr_i | input | 5 | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address |
| core_stby_i | input | 8 | Per-core standby-for-interrupt |
| cluster_stby_i | input | 2 | Per-cluster standby |
| wake_req_i | input | 8 | Per-core interrupt wake request |
| core_pwr_en_o | output | 8 | Per-core power enable |
| cluster_pwr_en_o | output | 2 | Per-cluster power enable |
| prog_err_o | output | 1 | Sticky programming error |

## Verification
Some properties are checked by the assertions on every cycle. These are the structural invariants: a powered core implies a powered cluster, and a pending flag implies the target is on. They also check that a core only loses power after a seen standby, a cluster power-down or a reset-pin pulse, that a core that comes on carries a software or wake reason, and that the error flag never drops. The bench scenarios cover the rest. Only they can show the exact edge on which a deferred power-down lands, which request wins when a wake and a software request meet, that ignored identifier bits and out-of-range targets truly leave the state alone, and that the status word read back matches the latched core.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [2:0] {
        REG_CORE_OFF    = 3'd0,
        REG_CORE_ON     = 3'd1,
        REG_CLUSTER_OFF = 3'd2,
        REG_WAKE_CFG    = 3'd3,
        REG_STATUS      = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        WHY_COLD  = 2'b00,
        WHY_PIN   = 2'b01,
        WHY_SW_ON = 2'b10,
        WHY_WAKE  = 2'b11
    } why_e;

    localparam int ID_W     = 24;
    localparam int WAKE_BIT = 31;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pcc_id_decode.sv
module pcc_id_decode #(
    parameter int NCL = 2,
    parameter int CPC = 4,
    parameter int CW  = 3,
    parameter int LW  = 1
) (
    input  logic [15:0]   id_i,
    output logic          core_ok_o,
    output logic          cluster_ok_o,
    output logic [CW-1:0] core_o,
    output logic [LW-1:0] cluster_o
);
    always_comb begin
        cluster_ok_o = int'(id_i[15:8]) < NCL;
        core_ok_o    = cluster_ok_o && (int'(id_i[7:0]) < CPC);
        cluster_o    = LW'(id_i[15:8]);
        core_o       = CW'(int'(id_i[15:8]) * CPC + int'(id_i[7:0]));
    end
endmodule

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
    import pcc_pkg::*;
#(
    parameter int NCL = 2,
    parameter int CPC = 4,
    parameter int NC  = NCL * CPC,
    parameter int CW  = 3,
    parameter int LW  = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rst_pin_i,
    input  logic [NC-1:0]         core_stby_i,
    input  logic [NCL-1:0]        cluster_stby_i,
    input  logic [NC-1:0]         wake_req_i,
    input  logic                  wr_en_i,
    input  logic [2:0]            wr_sel_i,
    input  logic                  wr_wake_bit_i,
    input  logic [ID_W-1:0]       wr_id_i,
    input  logic                  wr_core_ok_i,
    input  logic                  wr_cluster_ok_i,
    input  logic [CW-1:0]         wr_core_i,
    input  logic [LW-1:0]         wr_cluster_i,
    output logic [NC-1:0]         core_on_o,
    output logic [NC-1:0]         core_pend_o,
    output logic [NC-1:0]         wake_en_o,
    output logic [NC-1:0][1:0]    reason_o,
    output logic [NCL-1:0]        cluster_on_o,
    output logic [NCL-1:0]        cluster_pend_o,
    output logic                  prog_err_o,
    output logic [ID_W-1:0]       stat_id_o
);
    typedef struct packed {
        logic [NC-1:0]      core_on;
        logic [NC-1:0]      core_pend;
        logic [NC-1:0]      wake_en;
        logic [NC-1:0][1:0] reason;
        logic [NCL-1:0]     cl_on;
        logic [NCL-1:0]     cl_pend;
        logic               err;
        logic [ID_W-1:0]    stat_id;
    } state_t;

    localparam logic [NC-1:0]  BOOT_CORES    = NC'(1);
    localparam logic [NCL-1:0] BOOT_CLUSTERS = NCL'(1);

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst_pin_i) begin
            s_d.core_on   = BOOT_CORES;
            s_d.core_pend = '0;
            s_d.wake_en   = '0;
            s_d.cl_on     = BOOT_CLUSTERS;
            s_d.cl_pend   = '0;
            for (int i = 0; i < NC; i++) s_d.reason[i] = WHY_PIN;
        end else begin
            // deferred core power-down
            for (int i = 0; i < NC; i++) begin
                if (s_q.core_on[i] && s_q.core_pend[i] && core_stby_i[i]) begin
                    s_d.core_on[i]   = 1'b0;
                    s_d.core_pend[i] = 1'b0;
                end
            end
            // deferred cluster power-down takes its cores along
            for (int c = 0; c < NCL; c++) begin
                if (s_q.cl_on[c] && s_q.cl_pend[c] && cluster_stby_i[c]) begin
                    s_d.cl_on[c]   = 1'b0;
                    s_d.cl_pend[c] = 1'b0;
                    for (int k = 0; k < CPC; k++) begin
                        s_d.core_on[c*CPC+k]   = 1'b0;
                        s_d.core_pend[c*CPC+k] = 1'b0;
                    end
                end
            end
            // interrupt wake
            for (int i = 0; i < NC; i++) begin
                if (!s_q.core_on[i] && s_q.wake_en[i] && wake_req_i[i]) begin
                    s_d.core_on[i]       = 1'b1;
                    s_d.reason[i]        = WHY_WAKE;
                    s_d.cl_on[i/CPC]     = 1'b1;
                    s_d.cl_pend[i/CPC]   = 1'b0;
                end
            end
            // register writes
            if (wr_en_i) begin
                case (wr_sel_i)
                    REG_CORE_OFF: begin
                        if (wr_core_ok_i && s_d.core_on[wr_core_i])
                            s_d.core_pend[wr_core_i] = 1'b1;
                    end
                    REG_CORE_ON: begin
                        if (wr_core_ok_i) begin
                            if (!s_q.core_on[wr_core_i]) begin
                                s_d.core_on[wr_core_i]   = 1'b1;
                                s_d.core_pend[wr_core_i] = 1'b0;
                                s_d.reason[wr_core_i]    = WHY_SW_ON;
                                s_d.cl_on[wr_cluster_i]  = 1'b1;
                                s_d.cl_pend[wr_cluster_i] = 1'b0;
                            end else if (s_q.core_pend[wr_core_i]) begin
                                s_d.core_on[wr_core_i]   = 1'b1;
                                s_d.core_pend[wr_core_i] = 1'b0;
                                s_d.cl_on[wr_cluster_i]  = 1'b1;
                                s_d.cl_pend[wr_cluster_i] = 1'b0;
                            end else begin
                                s_d.err = 1'b1;
                            end
                        end
                    end
                    REG_CLUSTER_OFF: begin
                        if (wr_cluster_ok_i && s_d.cl_on[wr_cluster_i])
                            s_d.cl_pend[wr_cluster_i] = 1'b1;
                    end
                    REG_WAKE_CFG: begin
                        if (wr_core_ok_i) s_d.wake_en[wr_core_i] = wr_wake_bit_i;
                    end
                    REG_STATUS: s_d.stat_id = wr_id_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.core_on   <= BOOT_CORES;
            s_q.core_pend <= '0;
            s_q.wake_en   <= '0;
            s_q.reason    <= '0;
            s_q.cl_on     <= BOOT_CLUSTERS;
            s_q.cl_pend   <= '0;
            s_q.err       <= 1'b0;
            s_q.stat_id   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign core_on_o      = s_q.core_on;
    assign core_pend_o    = s_q.core_pend;
    assign wake_en_o      = s_q.wake_en;
    assign reason_o       = s_q.reason;
    assign cluster_on_o   = s_q.cl_on;
    assign cluster_pend_o = s_q.cl_pend;
    assign prog_err_o     = s_q.err;
    assign stat_id_o      = s_q.stat_id;

    for (genvar g = 0; g < NC; g++) begin : g_core_chk
        assert_core_needs_cluster_R10: assert property (@(posedge clk) disable iff (!rst_n)
            core_on_o[g] |-> cluster_on_o[g/CPC]);
        assert_pend_only_when_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
            core_pend_o[g] |-> core_on_o[g]);
        assert_power_loss_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(core_on_o[g]) |-> ($past(core_pend_o[g] && core_stby_i[g])
                || $past(cluster_pend_o[g/CPC] && cluster_stby_i[g/CPC])
                || $past(rst_pin_i)));
        assert_rise_reason_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(core_on_o[g]) |-> (reason_o[g] == WHY_SW_ON || reason_o[g] == WHY_WAKE
                || $past(rst_pin_i)));
    end

    for (genvar c = 0; c < NCL; c++) begin : g_cl_chk
        assert_cluster_pend_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
            cluster_pend_o[c] |-> cluster_on_o[c]);
    end

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_err_o) |-> prog_err_o);
endmodule

// File: rtl/pcc_status.sv
module pcc_status
    import pcc_pkg::*;
#(
    parameter int NCL        = 2,
    parameter int CPC        = 4,
    parameter int NC         = NCL * CPC,
    parameter int CW         = 3,
    parameter int LW         = 1,
    parameter bit L2_PRESENT = 1'b0
) (
    input  logic                 rd_ok_i,
    input  logic [2:0]           rd_sel_i,
    input  logic [ID_W-1:0]      stat_id_i,
    input  logic                 stat_core_ok_i,
    input  logic [CW-1:0]        stat_core_i,
    input  logic [LW-1:0]        stat_cluster_i,
    input  logic [NC-1:0]        core_on_i,
    input  logic [NC-1:0]        core_pend_i,
    input  logic [NC-1:0]        wake_en_i,
    input  logic [NC-1:0][1:0]   reason_i,
    input  logic [NCL-1:0]       cluster_on_i,
    input  logic [NCL-1:0]       cluster_pend_i,
    output logic [31:0]          rdata_o
);
    logic [7:0] flags;

    always_comb begin
        flags = '0;
        if (stat_core_ok_i) begin
            flags = {L2_PRESENT ? (|cluster_on_i) : 1'b0,
                     cluster_on_i[stat_cluster_i],
                     core_on_i[stat_core_i],
                     wake_en_i[stat_core_i],
                     cluster_pend_i[stat_cluster_i],
                     core_pend_i[stat_core_i],
                     reason_i[stat_core_i]};
        end
        rdata_o = '0;
        if (rd_ok_i && rd_sel_i == REG_STATUS) rdata_o = {flags, stat_id_i};
    end
endmodule

// File: rtl/cluster_pwr_ctrl.sv
module cluster_pwr_ctrl
    import pcc_pkg::*;
#(
    parameter int NUM_CLUSTERS      = 2,
    parameter int CORES_PER_CLUSTER = 4,
    parameter bit L2_PRESENT        = 1'b0,
    parameter int ADDR_W            = 5,
    parameter int NUM_CORES         = NUM_CLUSTERS * CORES_PER_CLUSTER
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rst_pin_i,
    input  logic [ADDR_W-1:0]       bus_addr_i,
    input  logic                    bus_we_i,
    input  logic [31:0]             bus_wdata_i,
    output logic [31:0]             bus_rdata_o,
    input  logic [NUM_CORES-1:0]    core_stby_i,
    input  logic [NUM_CLUSTERS-1:0] cluster_stby_i,
    input  logic [NUM_CORES-1:0]    wake_req_i,
    output logic [NUM_CORES-1:0]    core_pwr_en_o,
    output logic [NUM_CLUSTERS-1:0] cluster_pwr_en_o,
    output logic                    prog_err_o
);
    localparam int CW = idx_width(NUM_CORES);
    localparam int LW = idx_width(NUM_CLUSTERS);

    logic                          aligned, in_map;
    logic [2:0]                    sel;
    logic                          unused_bits;
    logic                          wr_core_ok, wr_cl_ok, st_core_ok, st_cl_ok;
    logic [CW-1:0]                 wr_core, st_core;
    logic [LW-1:0]                 wr_cl, st_cl;
    logic [NUM_CORES-1:0]          core_on, core_pend, wake_en;
    logic [NUM_CORES-1:0][1:0]     reason;
    logic [NUM_CLUSTERS-1:0]       cl_on, cl_pend;
    logic [ID_W-1:0]               stat_id;

    always_comb begin
        aligned = (bus_addr_i[1:0] == 2'b00);
        sel     = 3'(bus_addr_i[ADDR_W-1:2]);
        in_map  = aligned && (int'(bus_addr_i[ADDR_W-1:2]) <= int'(REG_STATUS));
    end

    assign unused_bits = ^bus_wdata_i[30:24];

    pcc_id_decode #(.NCL(NUM_CLUSTERS), .CPC(CORES_PER_CLUSTER), .CW(CW), .LW(LW)) u_wr_dec (
        .id_i(bus_wdata_i[15:0]), .core_ok_o(wr_core_ok), .cluster_ok_o(wr_cl_ok),
        .core_o(wr_core), .cluster_o(wr_cl));

    pcc_id_decode #(.NCL(NUM_CLUSTERS), .CPC(CORES_PER_CLUSTER), .CW(CW), .LW(LW)) u_st_dec (
        .id_i(stat_id[15:0]), .core_ok_o(st_core_ok), .cluster_ok_o(st_cl_ok),
        .core_o(st_core), .cluster_o(st_cl));

    pcc_ctrl #(.NCL(NUM_CLUSTERS), .CPC(CORES_PER_CLUSTER), .NC(NUM_CORES), .CW(CW), .LW(LW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin_i),
        .core_stby_i(core_stby_i), .cluster_stby_i(cluster_stby_i), .wake_req_i(wake_req_i),
        .wr_en_i(bus_we_i && in_map), .wr_sel_i(sel), .wr_wake_bit_i(bus_wdata_i[WAKE_BIT]),
        .wr_id_i(bus_wdata_i[ID_W-1:0]), .wr_core_ok_i(wr_core_ok), .wr_cluster_ok_i(wr_cl_ok),
        .wr_core_i(wr_core), .wr_cluster_i(wr_cl),
        .core_on_o(core_on), .core_pend_o(core_pend), .wake_en_o(wake_en), .reason_o(reason),
        .cluster_on_o(cl_on), .cluster_pend_o(cl_pend), .prog_err_o(prog_err_o),
        .stat_id_o(stat_id));

    pcc_status #(.NCL(NUM_CLUSTERS), .CPC(CORES_PER_CLUSTER), .NC(NUM_CORES), .CW(CW), .LW(LW),
                 .L2_PRESENT(L2_PRESENT)) u_status (
        .rd_ok_i(in_map), .rd_sel_i(sel), .stat_id_i(stat_id), .stat_core_ok_i(st_core_ok && st_cl_ok),
        .stat_core_i(st_core), .stat_cluster_i(st_cl),
        .core_on_i(core_on), .core_pend_i(core_pend), .wake_en_i(wake_en), .reason_i(reason),
        .cluster_on_i(cl_on), .cluster_pend_i(cl_pend), .rdata_o(bus_rdata_o));

    assign core_pwr_en_o    = core_on;
    assign cluster_pwr_en_o = cl_on;
endmodule

// File: tb/cluster_pwr_ctrl_test.sv
module cluster_pwr_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCL = 2;
    localparam int CPC = 4;
    localparam int NC  = NCL * CPC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_pin = 1'b0;
    logic [4:0] addr = '0;
    logic we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NC-1:0] stby = '0;
    logic [NCL-1:0] cstby = '0;
    logic [NC-1:0] wake = '0;
    logic [NC-1:0] core_pwr;
    logic [NCL-1:0] cl_pwr;
    logic err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model state
    logic [NC-1:0] m_on, m_pend, m_wen;
    logic [1:0] m_why [NC];
    logic [NCL-1:0] m_clon, m_cpend;
    logic m_err;
    logic [23:0] m_sid;

    always #(CLK_PERIOD/2) clk = ~clk;

    cluster_pwr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_pin_i(rst_pin), .bus_addr_i(addr), .bus_we_i(we),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .core_stby_i(stby), .cluster_stby_i(cstby),
        .wake_req_i(wake), .core_pwr_en_o(core_pwr), .cluster_pwr_en_o(cl_pwr), .prog_err_o(err));

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", what, got, exp, $time);
        end
    endtask

    task automatic model_boot(input logic [1:0] why);
        m_on = NC'(1); m_pend = '0; m_wen = '0; m_clon = NCL'(1); m_cpend = '0;
        for (int i = 0; i < NC; i++) m_why[i] = why;
    endtask

    function automatic logic [31:0] exp_rdata();
        int c, l, ix;
        logic [7:0] f;
        if (addr[1:0] != 2'b00 || addr[4:2] != 3'd4) return 32'h0;
        c = int'(m_sid[7:0]); l = int'(m_sid[15:8]);
        f = '0;
        if (l < NCL && c < CPC) begin
            ix = l * CPC + c;
            f = {1'b0, m_clon[l], m_on[ix], m_wen[ix], m_cpend[l], m_pend[ix], m_why[ix]};
        end
        return {f, m_sid};
    endfunction

    task automatic model_step();
        logic [NC-1:0] on, pend, wen;
        logic [NCL-1:0] clon, cpend;
        int c, l, ix;
        bit cok, lok;
        on = m_on; pend = m_pend; wen = m_wen; clon = m_clon; cpend = m_cpend;
        if (rst_pin) begin
            model_boot(2'b01);
            return;
        end
        for (int i = 0; i < NC; i++)
            if (m_on[i] && m_pend[i] && stby[i]) begin on[i] = 0; pend[i] = 0; end
        for (int k = 0; k < NCL; k++)
            if (m_clon[k] && m_cpend[k] && cstby[k]) begin
                clon[k] = 0; cpend[k] = 0;
                for (int j = 0; j < CPC; j++) begin on[k*CPC+j] = 0; pend[k*CPC+j] = 0; end
            end
        for (int i = 0; i < NC; i++)
            if (!m_on[i] && m_wen[i] && wake[i]) begin
                on[i] = 1; m_why[i] = 2'b11; clon[i/CPC] = 1; cpend[i/CPC] = 0;
            end
        c = int'(wdata[7:0]); l = int'(wdata[15:8]);
        lok = l < NCL; cok = lok && c < CPC; ix = l * CPC + c;
        if (we && addr[1:0] == 2'b00) begin
            case (addr[4:2])
                3'd0: if (cok && on[ix]) pend[ix] = 1;
                3'd1: if (cok) begin
                    if (!m_on[ix]) begin
                        on[ix] = 1; pend[ix] = 0; m_why[ix] = 2'b10; clon[l] = 1; cpend[l] = 0;
                    end else if (m_pend[ix]) begin
                        on[ix] = 1; pend[ix] = 0; clon[l] = 1; cpend[l] = 0;
                    end else m_err = 1;
                end
                3'd2: if (lok && clon[l]) cpend[l] = 1;
                3'd3: if (cok) wen[ix] = wdata[31];
                3'd4: m_sid = wdata[23:0];
                default: ;
            endcase
        end
        m_on = on; m_pend = pend; m_wen = wen; m_clon = clon; m_cpend = cpend;
    endtask

    task automatic check_all();
        chk("R3 R4 R5 R7 R8 R10 core power", 32'(core_pwr), 32'(m_on));
        chk("R4 R5 R7 R10 cluster power", 32'(cl_pwr), 32'(m_clon));
        chk("R6 error flag", 32'(err), 32'(m_err));
        chk("R2 R9 R11 read data", rdata, exp_rdata());
    endtask

    task automatic cycle();
        #1;
        check_all();
        model_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        cycle();
        we = 1'b0;
    endtask

    task automatic read_status(input string what, input logic [31:0] exp);
        addr = 5'h10; we = 1'b0;
        #1;
        chk(what, rdata, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        model_boot(2'b00); m_err = 0; m_sid = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: boot state
        chk("R1 boot cores", 32'(core_pwr), 32'h01);
        chk("R1 boot clusters", 32'(cl_pwr), 32'h1);
        chk("R1 boot error", 32'(err), 32'h0);
        read_status("R1 R9 core0 status after cold reset", 32'h6000_0000);

        // R2 R5: junk high bits, power on cluster1 core2
        wr(5'h04, 32'hAB00_0102);
        chk("R2 R5 core6 on", 32'(core_pwr), 32'h41);
        chk("R5 cluster1 on", 32'(cl_pwr), 32'h3);

        // R3: deferred power-down
        wr(5'h0C, 32'h8000_0102);
        wr(5'h00, 32'h0000_0102);
        cycle(); cycle();
        chk("R3 still on without standby", 32'(core_pwr), 32'h41);
        stby = 8'h40; cycle(); stby = '0;
        chk("R3 off after standby", 32'(core_pwr), 32'h01);
        chk("R3 cluster kept", 32'(cl_pwr), 32'h3);

        // R7: interrupt wake
        wake = 8'h40; cycle(); wake = '0;
        chk("R7 wake power-up", 32'(core_pwr), 32'h41);
        wr(5'h10, 32'h0000_0102);
        read_status("R7 R9 status after wake", 32'h7300_0102);

        // R6: on request to a running core
        wr(5'h04, 32'h0000_0000);
        chk("R6 error set", 32'(err), 32'h1);

        // R2: out-of-range core
        wr(5'h04, 32'h0000_0004);
        chk("R2 out-of-range ignored", 32'(core_pwr), 32'h41);

        // R4: cluster off
        wr(5'h08, 32'h0000_0100);
        cstby = 2'b10; cycle(); cstby = '0;
        chk("R4 cluster1 off", 32'(cl_pwr), 32'h1);
        chk("R4 cores of cluster1 off", 32'(core_pwr), 32'h01);

        // R8: reset pin
        wr(5'h04, 32'h0000_0101);
        rst_pin = 1'b1; cycle(); rst_pin = 1'b0;
        chk("R8 boot cores", 32'(core_pwr), 32'h01);
        chk("R8 error kept", 32'(err), 32'h1);
        wr(5'h10, 32'h0000_0000);
        read_status("R8 R9 core0 reason pin", 32'h6100_0000);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 5) begin
                int op;
                op = $urandom_range(0, 5);
                addr = {3'(op), 2'b00};
                if ($urandom_range(0, 7) == 0) addr[1:0] = 2'($urandom_range(1, 3));
                wdata = {8'($urandom), 8'($urandom), 8'($urandom_range(0, 2)), 8'($urandom_range(0, 4))};
                we = 1'b1;
            end else begin
                we = 1'b0;
                addr = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h10;
            end
            for (int i = 0; i < NC; i++) begin
                stby[i] = ($urandom_range(0, 3) == 0);
                wake[i] = ($urandom_range(0, 3) == 0);
            end
            for (int k = 0; k < NCL; k++) cstby[k] = ($urandom_range(0, 5) == 0);
            rst_pin = ($urandom_range(0, 199) == 0);
            cycle();
        end
        we = 1'b0; rst_pin = 1'b0;
        cycle();

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule